// File: doc/BRIEF.md
# USB Bit-Level Transmit Serializer

This block turns a stream of bytes from a controlling processor into the line signalling of a low-speed or full-speed USB packet on one differential pair. Software handles CRCs and field packing and hands over finished bytes. The block adds everything that happens at the wire: a one-bit J lead-in when the output driver turns on, the synchronisation byte, least-significant-bit-first serialisation with no gaps between bytes, zero-bit insertion after long runs of ones, NRZI coding, and the closing SE0/SE0/J end-of-packet sequence. After that sequence it releases the output enable.

Bit timing comes from an external one-cycle strobe at the bit rate, for example 12 MHz for full speed. The wire changes only on that strobe. Bytes arrive over a valid/ready handshake into a single holding register. A flag sent with a byte marks it as the final byte. If the holding register is empty when a byte runs out and that byte was not marked final, the block signals an underrun and closes the packet anyway. A speed select swaps which line is high in the J state.

Top module: `usb_bit_tx`

## Requirements
- R1: After reset the output enable is low, `busy` is low, `tx_ready` is high, `underrun` is low, and the lines rest at the J levels.
- R2: A byte accepted while idle starts a packet. On the next strobe the enable rises with the line at J for one bit time. The strobes after that send the sync byte 0x80 least-significant bit first, which appears on the wire as KJKJKJKK. The enable stays high while `busy` is high.
- R3: Data bytes follow the sync byte least-significant bit first, one bit per strobe, with no idle bit between bytes.
- R4: After six consecutive one bits a zero bit is inserted. Trailing ones of the sync byte count toward the run, and a stuff bit due after the final data bit is still sent before the end-of-packet.
- R5: NRZI coding: a zero bit toggles the line between J and K, and a one bit leaves it unchanged.
- R6: End-of-packet is two bit times of SE0 (both lines low), then one bit time of J with the enable high. After that the enable falls.
- R7: With `low_speed` low, J is dp=1/dm=0 and K is dp=0/dm=1. With `low_speed` high, the two levels are swapped. SE0 is dp=0/dm=0 in both modes.
- R8: The block holds one pending byte. `tx_ready` is low while that register is occupied, and an offered byte is captured on a clock edge where both `tx_valid` and `tx_ready` are high.
- R9: A byte accepted with `tx_last` high is the final byte. The end-of-packet follows its last bit, or the stuff bit that follows it.
- R10: If a byte that was not marked final finishes while no byte is pending, `underrun` pulses high for exactly one clock and the packet closes with the normal end-of-packet.
- R11: The line levels and the enable change only on clock edges where `bit_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per bit time |
| low_speed | input | 1 | 1 selects low-speed line polarity |
| tx_valid | input | 1 | Byte offered |
| tx_data | input | BYTE_W | Byte to send |
| tx_last | input | 1 | Offered byte is the final byte of the packet |
| tx_ready | output | 1 | Holding register can take a byte |
| usb_dp | output | 1 | D+ line level |
| usb_dm | output | 1 | D- line level |
| usb_oe | output | 1 | Line driver enable |
| busy | output | 1 | Packet in progress |
| underrun | output | 1 | One-clock pulse when data ran out early |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a stuff threshold of six and sync byte 0x80. It strobes one bit every four clocks, which leaves enough clocks between strobes to refill the holding register and to check that the line stays quiet between strobes. Because the threshold is six, a run of all-ones bytes produces several stuff bits in one packet. The same threshold lets the trailing one of the sync byte join a run, and lets a stuff bit land after the final data bit. The bench also sends one packet at low-speed polarity and one packet that is starved of data.

// File: rtl/usb_tx_pkg.sv
// Shared types for the USB transmit serializer.
// Assumes: used by every module of the usb_bit_tx hierarchy.
package usb_tx_pkg;

    // Command from the bit generator to the line driver, applied on a strobe.
    typedef enum logic [2:0] {
        LC_NONE,
        LC_ZERO,
        LC_ONE,
        LC_SE0,
        LC_J,
        LC_START,
        LC_RELEASE
    } line_cmd_e;

    // Packet sequencing state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_SE0A,
        ST_SE0B,
        ST_JEND
    } tx_state_e;

endpackage

// File: rtl/usb_tx_hold.sv
// One-entry holding register between the byte producer and the serializer.
// Assumes: take is only raised while full is high.
module usb_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         in_last,
    input  logic         take,
    output logic         in_ready,
    output logic         full,
    output logic [W-1:0] data,
    output logic         last
);

    assign in_ready = ~full;

    // Capture an offered byte, or free the entry when the serializer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            last <= 1'b0;
        end else if (in_valid && !full) begin
            full <= 1'b1;
            data <= in_data;
            last <= in_last;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    assert_hold_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full && !take |=> full);
    assert_accept_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> full && (data == $past(in_data)));

endmodule

// File: rtl/usb_tx_line.sv
// Line state keeper: NRZI level, SE0 and output enable, with J/K polarity.
// Assumes: cmd is meaningful only while stb is high.
module usb_tx_line
    import usb_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stb,
    input  line_cmd_e cmd,
    input  logic      low_speed,
    output logic      dp,
    output logic      dm,
    output logic      oe
);

    logic lvl_j;   // 1 = J, 0 = K
    logic se0;

    // Apply one line command per bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_j <= 1'b1;
            se0   <= 1'b0;
            oe    <= 1'b0;
        end else if (stb) begin
            case (cmd)
                LC_ZERO:    lvl_j <= ~lvl_j;
                LC_SE0:     se0   <= 1'b1;
                LC_J: begin
                    lvl_j <= 1'b1;
                    se0   <= 1'b0;
                end
                LC_START: begin
                    lvl_j <= 1'b1;
                    se0   <= 1'b0;
                    oe    <= 1'b1;
                end
                LC_RELEASE: oe <= 1'b0;
                default: ;
            endcase
        end
    end

    // Map the abstract level onto the pair for the selected speed.
    always_comb begin
        dp = ~se0 & (lvl_j ^ low_speed);
        dm = ~se0 & ~(lvl_j ^ low_speed);
    end

    assert_release_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !se0);
    assert_line_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(lvl_j) && $stable(se0) && $stable(oe));

endmodule

// File: rtl/usb_tx_bitgen.sv
// Packet sequencer: sync, LSB-first shifting, zero-bit stuffing, EOP timing.
// Assumes: one stb pulse per bit time; hold_* come from usb_tx_hold.
module usb_tx_bitgen
    import usb_tx_pkg::*;
#(
    parameter int              BYTE_W    = 8,
    parameter int              STUFF_RUN = 6,
    parameter logic [BYTE_W-1:0] SYNC_PAT = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              hold_full,
    input  logic [BYTE_W-1:0] hold_data,
    input  logic              hold_last,
    output logic              take,
    output line_cmd_e         cmd,
    output logic              busy,
    output logic              underrun
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    tx_state_e         state;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  bitn;
    logic [RUN_W-1:0]  ones;
    logic              cur_last;
    logic              drain;
    logic              stuff_due;
    logic              last_bit;

    assign stuff_due = (ones == RUN_W'(STUFF_RUN));
    assign last_bit  = (bitn == CNT_W'(BYTE_W - 1));
    assign busy      = (state != ST_IDLE);

    // Choose the line command for this strobe and whether to take the pending byte.
    always_comb begin
        cmd  = LC_NONE;
        take = 1'b0;
        if (stb) begin
            case (state)
                ST_IDLE: if (hold_full) cmd = LC_START;
                ST_DATA: begin
                    if (stuff_due) begin
                        cmd = LC_ZERO;
                    end else if (drain) begin
                        cmd = LC_SE0;
                    end else begin
                        cmd  = sh[0] ? LC_ONE : LC_ZERO;
                        take = last_bit && !cur_last && hold_full;
                    end
                end
                ST_SE0B: cmd = LC_J;
                ST_JEND: cmd = LC_RELEASE;
                default: ;
            endcase
        end
    end

    // Advance the sequencer, shifter, bit counter and ones-run counter per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sh       <= '0;
            bitn     <= '0;
            ones     <= '0;
            cur_last <= 1'b0;
            drain    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (stb) begin
                case (state)
                    ST_IDLE: if (hold_full) begin
                        state    <= ST_DATA;
                        sh       <= SYNC_PAT;
                        bitn     <= '0;
                        ones     <= '0;
                        cur_last <= 1'b0;
                        drain    <= 1'b0;
                    end
                    ST_DATA: begin
                        if (stuff_due) begin
                            ones <= '0;
                        end else if (drain) begin
                            state <= ST_SE0A;
                            drain <= 1'b0;
                        end else begin
                            ones <= sh[0] ? ones + RUN_W'(1) : '0;
                            if (last_bit) begin
                                if (take) begin
                                    sh       <= hold_data;
                                    cur_last <= hold_last;
                                    bitn     <= '0;
                                end else begin
                                    drain    <= 1'b1;
                                    underrun <= ~cur_last;
                                end
                            end else begin
                                sh   <= sh >> 1;
                                bitn <= bitn + CNT_W'(1);
                            end
                        end
                    end
                    ST_SE0A: state <= ST_SE0B;
                    ST_SE0B: state <= ST_JEND;
                    ST_JEND: state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= RUN_W'(STUFF_RUN));
    assert_underrun_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);
    assert_underrun_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> drain);

endmodule

// File: rtl/usb_bit_tx.sv
// Top of the USB bit-level transmitter: holding register, sequencer, line driver.
// Assumes: bit_stb pulses one clock per bit time; low_speed changes only while idle.
module usb_bit_tx
    import usb_tx_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter int                STUFF_RUN = 6,
    parameter logic [BYTE_W-1:0] SYNC_PAT  = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              low_speed,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    output logic              tx_ready,
    output logic              usb_dp,
    output logic              usb_dm,
    output logic              usb_oe,
    output logic              busy,
    output logic              underrun
);

    logic              hold_full;
    logic [BYTE_W-1:0] hold_data;
    logic              hold_last;
    logic              take;
    line_cmd_e         cmd;

    usb_tx_hold #(.W(BYTE_W)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .in_last  (tx_last),
        .take     (take),
        .in_ready (tx_ready),
        .full     (hold_full),
        .data     (hold_data),
        .last     (hold_last)
    );

    usb_tx_bitgen #(
        .BYTE_W    (BYTE_W),
        .STUFF_RUN (STUFF_RUN),
        .SYNC_PAT  (SYNC_PAT)
    ) bitgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (bit_stb),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .hold_last (hold_last),
        .take      (take),
        .cmd       (cmd),
        .busy      (busy),
        .underrun  (underrun)
    );

    usb_tx_line line_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (bit_stb),
        .cmd       (cmd),
        .low_speed (low_speed),
        .dp        (usb_dp),
        .dm        (usb_dm),
        .oe        (usb_oe)
    );

    assert_busy_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> usb_oe);

endmodule

// File: tb/usb_bit_tx_tb_top.sv
module usb_bit_tx_tb_top;

    typedef struct {
        bit    oe;
        bit    dp;
        bit    dm;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b0;
    logic       low_speed = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_last = 1'b0;
    logic       tx_ready, usb_dp, usb_dm, usb_oe, busy, underrun;

    int   vectors = 0;
    int   fails = 0;
    int   urun_cnt = 0;
    int   stb_cnt = 0;
    bit   started = 0;
    bit   prev_live = 0;
    logic [2:0] prev_line = 3'b0;
    logic       prev_ls = 1'b0;
    exp_t expq[$];
    logic [7:0] pkt[$];

    always #4 clk = ~clk;

    usb_bit_tx dut_i (
        .clk(clk), .rst_n(rst_n), .bit_stb(stb), .low_speed(low_speed),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe),
        .busy(busy), .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_sym(input bit oe, input bit lvl_j, input bit se0, input string req);
        exp_t e;
        e.oe  = oe;
        e.dp  = se0 ? 1'b0 : (lvl_j ^ low_speed);
        e.dm  = se0 ? 1'b0 : ~(lvl_j ^ low_speed);
        e.req = req;
        expq.push_back(e);
    endtask

    // Build the expected wire stream for pkt[] and feed the bytes.
    task automatic run_packet(input bit mark_last, input string force_tag);
        bit    lvl = 1'b1;
        int    ones = 0;
        string tg;
        logic [7:0] byt;
        push_sym(1, 1, 0, force_tag == "" ? "R2" : force_tag);
        for (int k = 0; k <= pkt.size(); k++) begin
            byt = (k == 0) ? 8'h80 : pkt[k-1];
            tg  = (force_tag != "") ? force_tag : ((k == 0) ? "R2" : "R3,R5");
            for (int b = 0; b < 8; b++) begin
                if (byt[b] == 1'b0) begin
                    lvl = ~lvl;
                    ones = 0;
                end else begin
                    ones++;
                end
                push_sym(1, lvl, 0, tg);
                if (ones == 6) begin
                    lvl = ~lvl;
                    ones = 0;
                    push_sym(1, lvl, 0, force_tag == "" ? "R4" : force_tag);
                end
            end
        end
        tg = (force_tag != "") ? force_tag : "R6,R9";
        push_sym(1, 1, 1, tg);
        push_sym(1, 1, 1, tg);
        push_sym(1, 1, 0, tg);
        push_sym(0, 1, 0, tg);
        for (int i = 0; i < pkt.size(); i++) begin
            @(negedge clk);
            tx_valid = 1'b1;
            tx_data  = pkt[i];
            tx_last  = mark_last && (i == pkt.size() - 1);
            while (!tx_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
            if (i == 0) check(tx_ready == 1'b0, "R8", "ready while holding", tx_ready, 0);
        end
        while (expq.size() != 0 || busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(!usb_oe && !busy, "R6", "idle after packet", {usb_oe, busy}, 0);
    endtask

    // Strobe generator and monitor: sample the wire after each strobe edge.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (underrun) urun_cnt++;
            if (stb) begin
                if (started || usb_oe) begin
                    if (expq.size() == 0) begin
                        check(0, "R2", "unexpected line activity", usb_oe, 0);
                    end else begin
                        e = expq.pop_front();
                        check({usb_oe, usb_dp, usb_dm} == {e.oe, e.dp, e.dm}, e.req,
                              "wire oe/dp/dm", {usb_oe, usb_dp, usb_dm}, {e.oe, e.dp, e.dm});
                        started = e.oe;
                    end
                end
            end else if (prev_live && prev_ls == low_speed) begin
                check({usb_oe, usb_dp, usb_dm} == prev_line, "R11", "change without strobe",
                      {usb_oe, usb_dp, usb_dm}, prev_line);
            end
        end
        prev_line = {usb_oe, usb_dp, usb_dm};
        prev_ls   = low_speed;
        prev_live = rst_n;
        stb     <= (stb_cnt == 3);
        stb_cnt <= (stb_cnt + 1) % 4;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int u0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!usb_oe && !busy && tx_ready && !underrun, "R1", "reset outputs",
              {usb_oe, busy, tx_ready, underrun}, 4'b0010);
        check(usb_dp && !usb_dm, "R1", "idle J levels", {usb_dp, usb_dm}, 2'b10);

        pkt = '{8'hA5, 8'h3C};
        run_packet(1, "");
        pkt = '{8'hFF, 8'hFF, 8'h01};
        run_packet(1, "");
        pkt = '{8'hFC};
        run_packet(1, "");
        check(urun_cnt == 0, "R10", "no underrun on marked packets", urun_cnt, 0);

        low_speed = 1'b1;
        repeat (8) @(negedge clk);
        check(!usb_dp && usb_dm, "R7", "low-speed idle J", {usb_dp, usb_dm}, 2'b01);
        pkt = '{8'h69, 8'hFF};
        run_packet(1, "R7");
        low_speed = 1'b0;
        repeat (8) @(negedge clk);

        u0 = urun_cnt;
        pkt = '{8'h55, 8'h33};
        run_packet(0, "");
        check(urun_cnt == u0 + 1, "R10", "underrun pulse count", urun_cnt, u0 + 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule